// File: doc/BRIEF.md
# MSI-X Interrupt Request Controller

This block turns a single MSI-X interrupt request from application logic into one outgoing posted-write message request. The requester presents a 64-bit message address, a 32-bit message data word, a function number and a traffic class together with a request strobe. The block latches all four in the cycle the strobe is first seen.

Before anything is sent, the block checks the function number. Two physical functions and a parameterised number of virtual functions are valid targets, and each has its own MSI-X enable bit and function-mask bit. If the function number is valid, the function is enabled and it is not masked, the latched message is offered on a valid/ready output port. Otherwise nothing is offered.

Every request ends with a one-cycle acknowledge that carries an error flag. After the acknowledge, the requester drops its strobe for at least one cycle before it starts the next request.

Top module: `msix_req_ctrl`

## Requirements
- R1: Address, data, function number and traffic class are captured in the clock cycle in which `req_i` is first seen high while the block is idle. The offered message carries exactly those values, even if the inputs change afterwards.
- R2: Function number 0 selects physical function 0 (bit 0 of `pf_en_i`/`pf_mask_i`). Function number 1 selects physical function 1 (bit 1). Function number 2+k selects virtual function k (bit k of `vf_en_i`/`vf_mask_i`) for k from 0 to NUM_VF-1. Any other function number is invalid, is answered with an error acknowledge and produces no message.
- R3: A request to a function whose enable bit is 0 is answered with an error acknowledge and produces no message.
- R4: A request to a function whose function-mask bit is 1 is answered with an error acknowledge and produces no message.
- R5: `msg_valid_o` rises one cycle after a good request is captured. It stays high with stable contents until `msg_ready_i` is high at a clock edge. The cycle after that handshake, `ack_o` is high with `err_o` = 0.
- R6: For a failing request, `ack_o` is high with `err_o` = 1 in the cycle right after capture, and `msg_valid_o` stays low throughout.
- R7: `ack_o` is high for exactly one cycle per request.
- R8: After an acknowledge, no new request is captured until `req_i` has been seen low at a clock edge. A strobe held high after the acknowledge produces no second message and no second acknowledge.
- R9: While `rst_n` is low, and in the first cycle after reset, `msg_valid_o` and `ack_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Interrupt request strobe, held until acknowledge |
| req_fn_i | input | FN_W | Target function number |
| req_tc_i | input | TC_W | Traffic class for the message |
| req_addr_i | input | ADDR_W | Message address |
| req_data_i | input | DATA_W | Message data |
| pf_en_i | input | 2 | MSI-X enable, physical functions 0 and 1 |
| pf_mask_i | input | 2 | Function mask, physical functions 0 and 1 |
| vf_en_i | input | NUM_VF | MSI-X enable, virtual function k at bit k |
| vf_mask_i | input | NUM_VF | Function mask, virtual function k at bit k |
| ack_o | output | 1 | One-cycle request completion pulse |
| err_o | output | 1 | Error flag, meaningful while ack_o is high |
| msg_valid_o | output | 1 | Message request offered downstream |
| msg_ready_i | input | 1 | Downstream accepts the message |
| msg_addr_o | output | ADDR_W | Message address |
| msg_data_o | output | DATA_W | Message data |
| msg_fn_o | output | FN_W | Function number of the message |
| msg_tc_o | output | TC_W | Traffic class of the message |

## Verification
Results fall due at fixed distances from the edges that cause them:
- `msg_valid_o` is high one cycle after capture.
- An error acknowledge is high one cycle after capture.
- A good acknowledge is high one cycle after the edge at which valid and ready are both high.
- A new capture can happen no earlier than two cycles after the acknowledge.

The bench runs a behavioural model that is updated at the same clock edges as the design, from the same inputs. It compares acknowledge, error, valid and message fields on every falling edge, so each result is checked in the exact cycle it is due. Per-request checks also count accepted handshakes and confirm that the acknowledge has gone low one cycle later.

// File: rtl/msix_pkg.sv
package msix_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_e;

    localparam int unsigned NUM_PF = 2;

endpackage

// File: rtl/msix_fn_check.sv
module msix_fn_check #(
    parameter int unsigned NUM_FN = 6,
    parameter int unsigned FN_W   = 8
) (
    input  logic [FN_W-1:0]   fn_i,
    input  logic [NUM_FN-1:0] en_i,
    input  logic [NUM_FN-1:0] mask_i,
    output logic              ok_o
);

    logic [NUM_FN-1:0] hit;

    for (genvar i = 0; i < NUM_FN; i++) begin : g_fn
        assign hit[i] = (fn_i == FN_W'(i)) && en_i[i] && !mask_i[i];
    end

    assign ok_o = |hit;

endmodule

// File: rtl/msix_req_fsm.sv
module msix_req_fsm #(
    parameter int unsigned FN_W   = 8,
    parameter int unsigned TC_W   = 3,
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              fn_ok_i,
    input  logic [FN_W-1:0]   req_fn_i,
    input  logic [TC_W-1:0]   req_tc_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_data_i,
    input  logic              msg_ready_i,
    output logic              msg_valid_o,
    output logic [ADDR_W-1:0] msg_addr_o,
    output logic [DATA_W-1:0] msg_data_o,
    output logic [FN_W-1:0]   msg_fn_o,
    output logic [TC_W-1:0]   msg_tc_o,
    output logic              ack_o,
    output logic              err_o
);
    import msix_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [FN_W-1:0]   fn;
        logic [TC_W-1:0]   tc;
    } rec_t;

    typedef struct packed {
        ctl_state_e st;
        logic       ack;
        logic       err;
        rec_t       rec;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_i) begin
                    d.rec.addr = req_addr_i;
                    d.rec.data = req_data_i;
                    d.rec.fn   = req_fn_i;
                    d.rec.tc   = req_tc_i;
                    if (fn_ok_i) begin
                        d.st = ST_SEND;
                    end else begin
                        d.st  = ST_DONE;
                        d.ack = 1'b1;
                        d.err = 1'b1;
                    end
                end
            end
            ST_SEND: begin
                if (msg_ready_i) begin
                    d.st  = ST_DONE;
                    d.ack = 1'b1;
                    d.err = 1'b0;
                end
            end
            ST_DONE: begin
                if (!req_i) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ack: 1'b0, err: 1'b0, rec: '0};
        end else begin
            q <= d;
        end
    end

    assign msg_valid_o = (q.st == ST_SEND);
    assign msg_addr_o  = q.rec.addr;
    assign msg_data_o  = q.rec.data;
    assign msg_fn_o    = q.rec.fn;
    assign msg_tc_o    = q.rec.tc;
    assign ack_o       = q.ack;
    assign err_o       = q.err;

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R5
    hold_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o)
            && $stable(msg_data_o) && $stable(msg_fn_o) && $stable(msg_tc_o));

    // R5
    good_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o && msg_ready_i |=> ack_o && !err_o && !msg_valid_o);

    // R6
    err_no_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && err_o |-> !$past(msg_valid_o));

    // R8
    held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && req_i |=> !msg_valid_o && !ack_o);

endmodule

// File: rtl/msix_req_ctrl.sv
module msix_req_ctrl #(
    parameter int unsigned NUM_VF = 4,
    parameter int unsigned FN_W   = 8,
    parameter int unsigned TC_W   = 3,
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [FN_W-1:0]   req_fn_i,
    input  logic [TC_W-1:0]   req_tc_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_data_i,
    input  logic [1:0]        pf_en_i,
    input  logic [1:0]        pf_mask_i,
    input  logic [NUM_VF-1:0] vf_en_i,
    input  logic [NUM_VF-1:0] vf_mask_i,
    output logic              ack_o,
    output logic              err_o,
    output logic              msg_valid_o,
    input  logic              msg_ready_i,
    output logic [ADDR_W-1:0] msg_addr_o,
    output logic [DATA_W-1:0] msg_data_o,
    output logic [FN_W-1:0]   msg_fn_o,
    output logic [TC_W-1:0]   msg_tc_o
);

    localparam int unsigned NUM_FN = msix_pkg::NUM_PF + NUM_VF;

    logic fn_ok;

    msix_fn_check #(
        .NUM_FN (NUM_FN),
        .FN_W   (FN_W)
    ) u_chk (
        .fn_i   (req_fn_i),
        .en_i   ({vf_en_i, pf_en_i}),
        .mask_i ({vf_mask_i, pf_mask_i}),
        .ok_o   (fn_ok)
    );

    msix_req_fsm #(
        .FN_W   (FN_W),
        .TC_W   (TC_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .fn_ok_i     (fn_ok),
        .req_fn_i    (req_fn_i),
        .req_tc_i    (req_tc_i),
        .req_addr_i  (req_addr_i),
        .req_data_i  (req_data_i),
        .msg_ready_i (msg_ready_i),
        .msg_valid_o (msg_valid_o),
        .msg_addr_o  (msg_addr_o),
        .msg_data_o  (msg_data_o),
        .msg_fn_o    (msg_fn_o),
        .msg_tc_o    (msg_tc_o),
        .ack_o       (ack_o),
        .err_o       (err_o)
    );

endmodule

// File: tb/sim_msix_req_ctrl.sv
`timescale 1ns/1ps
module sim_msix_req_ctrl;

    localparam int NV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  req_fn = '0;
    logic [2:0]  req_tc = '0;
    logic [63:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [1:0]  pf_en = 2'b11;
    logic [1:0]  pf_mask = 2'b00;
    logic [NV-1:0] vf_en = '1;
    logic [NV-1:0] vf_mask = '0;
    logic        msg_ready = 1'b0;
    logic        ack_o, err_o, msg_valid_o;
    logic [63:0] msg_addr_o;
    logic [31:0] msg_data_o;
    logic [7:0]  msg_fn_o;
    logic [2:0]  msg_tc_o;

    int total = 0;
    int bad = 0;
    int rdy_delay = 0;
    int vcnt = 0;
    int dut_sent = 0;
    int cyc = 0;
    string tag = "R9";

    always #2.5 clk = ~clk;

    msix_req_ctrl #(.NUM_VF(NV)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_fn_i(req_fn),
        .req_tc_i(req_tc), .req_addr_i(req_addr), .req_data_i(req_data),
        .pf_en_i(pf_en), .pf_mask_i(pf_mask), .vf_en_i(vf_en),
        .vf_mask_i(vf_mask), .ack_o(ack_o), .err_o(err_o),
        .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready),
        .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
        .msg_fn_o(msg_fn_o), .msg_tc_o(msg_tc_o)
    );

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", rq, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    function automatic bit fn_good(input int f);
        if (f < 2) return pf_en[f] && !pf_mask[f];
        if (f < 2 + NV) return vf_en[f-2] && !vf_mask[f-2];
        return 1'b0;
    endfunction

    bit m_valid = 0, m_ack = 0, m_err = 0, m_hold = 0, m_nack;
    logic [63:0] m_addr;
    logic [31:0] m_data;
    logic [7:0]  m_fn;
    logic [2:0]  m_tc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0; m_ack = 0; m_err = 0; m_hold = 0;
        end else begin
            if (msg_valid_o && msg_ready) dut_sent++;
            m_nack = 0;
            if (m_hold) begin
                if (!req) m_hold = 0;
            end else if (m_valid) begin
                if (msg_ready) begin
                    m_valid = 0; m_nack = 1; m_err = 0; m_hold = 1;
                end
            end else if (req) begin
                if (!fn_good(int'(req_fn))) begin
                    m_nack = 1; m_err = 1; m_hold = 1;
                end else begin
                    m_valid = 1; m_addr = req_addr; m_data = req_data;
                    m_fn = req_fn; m_tc = req_tc;
                end
            end
            m_ack = m_nack;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            check({tag, " R7 ack"}, 64'(ack_o), 64'(m_ack));
            check({tag, " R5 valid"}, 64'(msg_valid_o), 64'(m_valid));
            if (m_ack) check({tag, " err"}, 64'(err_o), 64'(m_err));
            if (m_valid) begin
                check({tag, " R1 addr"}, msg_addr_o, m_addr);
                check({tag, " R1 data"}, 64'(msg_data_o), 64'(m_data));
                check({tag, " R1 fn"}, 64'(msg_fn_o), 64'(m_fn));
                check({tag, " R1 tc"}, 64'(msg_tc_o), 64'(m_tc));
            end
        end
    end

    // Downstream ready driver
    always @(negedge clk) begin
        if (msg_valid_o) begin
            msg_ready <= (vcnt >= rdy_delay);
            vcnt++;
        end else begin
            msg_ready <= 1'b0;
            vcnt = 0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_req(input string t, input int fn, input logic [63:0] a,
                          input logic [31:0] dt, input logic [2:0] tc,
                          input int delay, input int hold, input bit exp_err);
        int sent0;
        bit seen;
        tag = t;
        rdy_delay = delay;
        sent0 = dut_sent;
        @(negedge clk);
        req = 1; req_fn = 8'(fn); req_addr = a; req_data = dt; req_tc = tc;
        @(negedge clk);
        // R1: change inputs after capture; message must keep captured values
        req_addr = ~a; req_data = ~dt; req_tc = ~tc;
        seen = ack_o;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            seen = ack_o;
        end
        check({t, " ack seen"}, 64'(seen), 64'd1);
        check({t, " err at ack"}, 64'(err_o), 64'(exp_err));
        @(negedge clk);
        check({t, " R7 ack low next"}, 64'(ack_o), 64'd0);
        repeat (hold) @(negedge clk);
        req = 0;
        @(negedge clk);
        check({t, " messages sent"}, 64'(dut_sent - sent0), exp_err ? 64'd0 : 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset valid", 64'(msg_valid_o), 64'd0);
        check("R9 reset ack", 64'(ack_o), 64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R9 post-reset valid", 64'(msg_valid_o), 64'd0);
        check("R9 post-reset ack", 64'(ack_o), 64'd0);

        do_req("R1 pf0", 0, 64'h1234_5678_9ABC_DEF0, 32'hCAFE_0001, 3'd2, 0, 0, 0);
        do_req("R5 pf1 slow ready", 1, 64'hFFFF_0000_0000_1000, 32'h0000_00AA, 3'd7, 3, 0, 0);
        do_req("R2 vf0", 2, 64'h0000_0000_FEE0_0000, 32'h55, 3'd0, 1, 0, 0);
        do_req("R2 vf last", 2 + NV - 1, 64'hA5A5_A5A5_5A5A_5A5A, 32'hDEAD_BEEF, 3'd5, 0, 0, 0);
        do_req("R2 R6 fn past vf", 2 + NV, 64'h10, 32'h1, 3'd1, 0, 0, 1);
        do_req("R2 R6 fn 255", 255, 64'h20, 32'h2, 3'd1, 0, 0, 1);

        pf_en = 2'b01;
        do_req("R3 pf1 disabled", 1, 64'h30, 32'h3, 3'd0, 0, 0, 1);
        do_req("R3 pf0 still on", 0, 64'h31, 32'h4, 3'd0, 0, 0, 0);
        pf_en = 2'b11;
        vf_en = 4'b1011;
        do_req("R3 vf2 disabled", 4, 64'h40, 32'h5, 3'd3, 0, 0, 1);
        vf_en = '1;

        vf_mask = 4'b0001;
        do_req("R4 vf0 masked", 2, 64'h50, 32'h6, 3'd4, 0, 0, 1);
        do_req("R4 vf1 unmasked", 3, 64'h51, 32'h7, 3'd4, 2, 0, 0);
        vf_mask = '0;
        pf_mask = 2'b01;
        do_req("R4 pf0 masked", 0, 64'h60, 32'h8, 3'd6, 0, 0, 1);
        pf_mask = 2'b00;

        do_req("R8 held after ack", 0, 64'h70, 32'h9, 3'd1, 0, 5, 0);
        do_req("R8 held after err", 200, 64'h71, 32'hA, 3'd1, 0, 4, 1);
        do_req("R6 back to back", 5, 64'h80, 32'hB, 3'd2, 0, 0, 0);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule